// File: doc/BRIEF.md
# Frame-Buffered Phase-Accumulator Step Generator

This block drives one motion axis from a queue of velocity commands. A host pushes 32-bit command words into a small on-chip queue. The generator takes one word at a time and adds its signed rate into a 28-bit phase accumulator for a programmed number of clock cycles, called a frame. It then takes the next word. Because every word lasts a known number of additions, the accumulator value at the end of each frame can be worked out exactly. The host only has to keep the queue from running dry; its writes do not need precise timing.

A command word may also overwrite the top three accumulator bits once, just before the first addition of its frame. The host uses this to move the phase to a safe point, for example to discard a leftover fraction or to prepare a reversal. Every change of the accumulator's top bit produced by an addition counts as one step. The pin pair can present these steps in either of two forms. In step/direction form the pins carry a step pulse and a direction level. In quadrature form they carry a two-bit Gray count. While the generator is disabled, the pins carry a plain output register instead.

Top module: `stepgen_frame`

## Requirements
- R1: After reset the pins are 00, the phase is 0, the queue is empty (half and full flags low) and the underrun flag is low.
- R2: The queue holds 16 words. The half flag is high whenever it holds 8 or more words. The full flag is high at 16 words, and a write while full is discarded.
- R3: Command bits [27:0] are a signed rate. Once enabled, the generator applies each word for exactly frame_len consecutive additions. It takes the next word in the cycle after the last of those additions, so the phase after k frames equals the sum of the k rate-times-frame_len products, modulo 2^28.
- R4: When command bit 31 is set, bits [30:28] replace phase bits [27:25] once, before the first addition of that word's frame. The lower phase bits are kept.
- R5: If a frame ends while the queue is empty, the rate becomes zero and the phase holds. The underrun flag is set on entry to that starved state and stays set until underrun_clr is raised. While the generator remains starved, it is not set again.
- R6: In step/direction mode (quad_mode=0), pins[0] is high for one cycle for each top-bit change caused by an addition. The pulse appears one cycle after the phase update. pins[1] is 1 while the active rate is non-negative and 0 while it is negative.
- R7: In quadrature mode (quad_mode=1), the pins follow the Gray sequence 00, 01, 11, 10. They advance one state per forward step and go back one state per reverse step, so no more than one pin changes per step.
- R8: While enable is low, the pins show gpio_out one cycle later. The phase, the frame position and the queue contents are held, and writes are still accepted.
- R9: A preset that changes the phase's top bit produces no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; low selects plain output |
| quad_mode | input | 1 | 0 step/direction, 1 quadrature |
| frame_len | input | 16 | Additions per command word (at least 1) |
| cmd_wr | input | 1 | Write strobe for the command queue |
| cmd_data | input | 32 | Command word: bit 31 preset enable, [30:28] preset, [27:0] rate |
| underrun_clr | input | 1 | Clears the underrun flag |
| gpio_out | input | 2 | Pin values used while disabled |
| pins | output | 2 | Step/dir, quadrature or plain output pins |
| phase | output | 28 | Current accumulator value |
| fifo_half | output | 1 | Queue holds at least half its capacity |
| fifo_full | output | 1 | Queue is full |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The assertions assume that frame_len never drops to zero. They also assume that enable and quad_mode change only between runs, so two samples taken in a row inside a quadrature run describe the same mode. The stimulus sets frame_len before each run and switches mode only while disabled. It keeps every rate at or below 2^26 in magnitude, so the top bit changes at most once per addition and a two-pin Gray jump can only come from a design fault. The expected phase values and step counts are worked out from the command words, addition by addition.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
  localparam int ACC_W = 28;
  localparam int PRE_W = 3;
  localparam int CMD_W = ACC_W + PRE_W + 1;

  typedef struct packed {
    logic             pre_en;
    logic [PRE_W-1:0] pre_val;
    logic [ACC_W-1:0] rate;
  } cmd_t;

  typedef enum logic {
    OUT_STEPDIR = 1'b0,
    OUT_QUAD    = 1'b1
  } out_mode_e;

  function automatic logic [1:0] gray2(input logic [1:0] bin);
    return {bin[1], bin[1] ^ bin[0]};
  endfunction
endpackage

// File: rtl/sg_cmd_fifo.sv
module sg_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign half    = (count >= CW'(DEPTH / 2));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: a write arriving while full with no pop leaves the level unchanged
  a_r2_full_drops: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));

  // R2: the level never exceeds the capacity
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/sg_phase_core.sv
module sg_phase_core import stepgen_pkg::*; #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [FRAME_W-1:0] frame_len,
  input  cmd_t               head,
  input  logic               head_valid,
  input  logic               clr_underrun,
  output logic               pop,
  output logic [ACC_W-1:0]   acc,
  output logic               step_evt,
  output logic               rate_neg,
  output logic               underrun
);
  localparam int LOW_W = ACC_W - PRE_W;

  logic [ACC_W-1:0]   rate_r;
  logic [FRAME_W-1:0] cnt;
  logic               starved;
  logic               boundary, take, advance, starve_now;
  logic [ACC_W-1:0]   base, use_rate, sum;

  always_comb begin
    boundary   = (cnt == '0);
    take       = en && boundary && head_valid;
    starve_now = en && boundary && !head_valid;
    advance    = en && (!boundary || take);
    base       = acc;
    if (take && head.pre_en) base = {head.pre_val, acc[LOW_W-1:0]};
    use_rate   = take ? head.rate : rate_r;
    sum        = base + use_rate;
  end

  assign pop      = take;
  assign rate_neg = rate_r[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rate_r   <= '0;
      cnt      <= '0;
      starved  <= 1'b0;
      step_evt <= 1'b0;
      underrun <= 1'b0;
    end else begin
      step_evt <= advance && (sum[ACC_W-1] != base[ACC_W-1]);
      if (advance) acc <= sum;
      if (take) begin
        rate_r  <= head.rate;
        cnt     <= frame_len - 1'b1;
        starved <= 1'b0;
      end else if (starve_now) begin
        rate_r  <= '0;
        starved <= 1'b1;
      end else if (en) begin
        cnt <= cnt - 1'b1;
      end
      if (starve_now && !starved) underrun <= 1'b1;
      else if (clr_underrun)      underrun <= 1'b0;
    end
  end

  // R8: no phase movement in the cycle after enable is low
  a_r8_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == $past(acc)));

  // R5: a starved frame boundary leaves the phase untouched
  a_r5_starve_hold: assert property (@(posedge clk) disable iff (rst)
    (en && boundary && !head_valid) |=> (acc == $past(acc)));

  // R5: the flag stays up until cleared
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (underrun && !clr_underrun) |=> underrun);
endmodule

// File: rtl/sg_pin_encoder.sv
module sg_pin_encoder import stepgen_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  out_mode_e  mode,
  input  logic       step_evt,
  input  logic       fwd,
  input  logic [1:0] gpio,
  output logic [1:0] pins
);
  logic [1:0] q, q_next;

  always_comb begin
    q_next = q;
    if (step_evt) q_next = fwd ? q + 2'd1 : q - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      pins <= '0;
    end else begin
      q <= q_next;
      if (!en)                   pins <= gpio;
      else if (mode == OUT_QUAD) pins <= gray2(q_next);
      else                       pins <= {fwd, step_evt};
    end
  end

  // R7: inside a quadrature run the pins change by at most one bit per cycle
  a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(en, 2) && ($past(mode) == OUT_QUAD) && ($past(mode, 2) == OUT_QUAD))
      |-> ($countones(pins ^ $past(pins)) <= 1));
endmodule

// File: rtl/stepgen_frame.sv
module stepgen_frame import stepgen_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               quad_mode,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic               underrun_clr,
  input  logic [1:0]         gpio_out,
  output logic [1:0]         pins,
  output logic [ACC_W-1:0]   phase,
  output logic               fifo_half,
  output logic               fifo_full,
  output logic               underrun
);
  logic [CMD_W-1:0] head_raw;
  logic             fifo_empty, pop, step_evt, rate_neg;
  out_mode_e        mode;

  assign mode = quad_mode ? OUT_QUAD : OUT_STEPDIR;

  sg_cmd_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_fifo (
    .clk(clk), .rst(rst), .push(cmd_wr), .din(cmd_data), .pop(pop),
    .dout(head_raw), .empty(fifo_empty), .full(fifo_full), .half(fifo_half)
  );

  sg_phase_core #(.FRAME_W(FRAME_W)) u_core (
    .clk(clk), .rst(rst), .en(enable), .frame_len(frame_len),
    .head(cmd_t'(head_raw)), .head_valid(!fifo_empty), .clr_underrun(underrun_clr),
    .pop(pop), .acc(phase), .step_evt(step_evt), .rate_neg(rate_neg),
    .underrun(underrun)
  );

  sg_pin_encoder u_enc (
    .clk(clk), .rst(rst), .en(enable), .mode(mode), .step_evt(step_evt),
    .fwd(!rate_neg), .gpio(gpio_out), .pins(pins)
  );
endmodule

// File: tb/tb_stepgen_frame.sv
module tb_stepgen_frame;
  logic        clk = 1'b0;
  logic        rst, enable, quad_mode, cmd_wr, underrun_clr;
  logic [15:0] frame_len;
  logic [31:0] cmd_data;
  logic [1:0]  gpio_out, pins;
  logic [27:0] phase;
  logic        fifo_half, fifo_full, underrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stepgen_frame dut (
    .clk(clk), .rst(rst), .enable(enable), .quad_mode(quad_mode),
    .frame_len(frame_len), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .underrun_clr(underrun_clr), .gpio_out(gpio_out), .pins(pins),
    .phase(phase), .fifo_half(fifo_half), .fifo_full(fifo_full),
    .underrun(underrun)
  );

  // command words: bit31 preset enable, [30:28] preset, [27:0] rate
  localparam logic [31:0] TBL [4] = '{
    32'h8400_0000,  // preset 000, rate +2^26
    32'h0E00_0000,  // rate -2^25
    32'h8012_3456,  // preset 000, small positive rate
    32'hF000_0000   // preset 111, rate 0: top bit flips with no step
  };
  localparam int FA = 10;
  localparam int FC = 4;

  logic [27:0] m_acc = '0;
  int m_fwd = 0, m_rev = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_frame(input logic [31:0] w, input int f);
    logic [27:0] s;
    if (w[31]) m_acc = {w[30:28], m_acc[24:0]};
    for (int i = 0; i < f; i++) begin
      s = m_acc + w[27:0];
      if (s[27] != m_acc[27]) begin
        if (w[27]) m_rev++; else m_fwd++;
      end
      m_acc = s;
    end
  endtask

  task automatic push(input logic [31:0] w);
    cmd_data = w;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  function automatic int gidx(input logic [1:0] p);
    case (p)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int obs_fwd, obs_rev, qf, qr, bad, prev, cur, d;
    rst = 1'b1; enable = 1'b0; quad_mode = 1'b0; cmd_wr = 1'b0;
    underrun_clr = 1'b0; frame_len = 16'(FA); cmd_data = '0; gpio_out = 2'b00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pins", pins, 2'b00);
    chk("R1 phase", phase, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 half", fifo_half, 0);
    chk("R1 full", fifo_full, 0);

    // load the table while disabled; pins follow gpio
    gpio_out = 2'b10;
    for (int k = 0; k < 4; k++) push(TBL[k]);
    chk("R8 gpio pins", pins, 2'b10);
    chk("R8 phase held", phase, 0);

    // walk the table in step/direction mode
    obs_fwd = 0; obs_rev = 0;
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      model_frame(TBL[k], FA);
      for (int c = 0; c < FA; c++) begin
        @(negedge clk);
        if (pins[0]) begin
          if (pins[1]) obs_fwd++; else obs_rev++;
        end
      end
      chk($sformatf("R3 R4 R9 phase after frame %0d", k), phase, m_acc);
      if (k == 1) chk("R6 dir low on negative rate", pins[1], 1'b0);
    end
    chk("R5 no underrun before boundary", underrun, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (pins[0]) begin
        if (pins[1]) obs_fwd++; else obs_rev++;
      end
      if (c == 0) chk("R5 underrun set at starved boundary", underrun, 1);
    end
    chk("R6 forward pulses", obs_fwd, m_fwd);
    chk("R6 reverse pulses", obs_rev, m_rev);
    chk("R6 dir high at zero rate", pins[1], 1'b1);
    chk("R5 phase held while starved", phase, m_acc);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    @(negedge clk);
    chk("R5 clear while starved", underrun, 0);

    // queue depth and quadrature run
    enable = 1'b0; quad_mode = 1'b1; frame_len = 16'(FC); gpio_out = 2'b01;
    for (int k = 0; k < 7; k++) push(32'h0400_0000);
    chk("R2 half low at 7", fifo_half, 0);
    push(32'h0400_0000);
    chk("R2 half high at 8", fifo_half, 1);
    for (int k = 0; k < 8; k++) push(32'h0C00_0000);
    chk("R2 full at 16", fifo_full, 1);
    push(32'h07FF_FFFF);
    chk("R2 full after dropped write", fifo_full, 1);
    chk("R8 phase held with queue loaded", phase, m_acc);
    chk("R8 gpio pins in quad mode", pins, 2'b01);
    for (int k = 0; k < 8; k++) model_frame(32'h0400_0000, FC);
    for (int k = 0; k < 8; k++) model_frame(32'h0C00_0000, FC);

    enable = 1'b1;
    @(negedge clk);
    prev = gidx(pins); qf = 0; qr = 0; bad = 0;
    for (int c = 0; c < 16 * FC + 6; c++) begin
      @(negedge clk);
      cur = gidx(pins);
      d = (cur - prev + 4) % 4;
      if (d == 1) qf++;
      else if (d == 3) qr++;
      else if (d == 2) bad++;
      prev = cur;
    end
    chk("R7 forward quad steps", qf, 16);
    chk("R7 reverse quad steps", qr, 16);
    chk("R7 no two-bit jumps", bad, 0);
    chk("R2 R3 phase excludes dropped write", phase, m_acc);
    chk("R5 underrun after drain", underrun, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule